// File: doc/BRIEF.md
# Synchronous Master Serial Receiver

This block receives serial words as the clock master of a two-wire synchronous link. It generates a shift clock from a programmable divider and drives it on `sck`. It samples the incoming data line `sdi` once per shift-clock period, on the high-to-low transition of `sck`. Bits arrive least significant first. When a word is complete, its eight data bits go to a parallel holding register. In nine-bit mode the extra bit goes to a separate status output.

Two receive enables control clocking. The one-shot enable is set by a write pulse and clears itself after one word. The continuous enable is a level, and while it is high words arrive back to back. When both are active, the continuous enable decides the behaviour. A completed word raises a receive-complete flag, which is cleared by a read strobe. The flag drives an interrupt request through an enable gate. A word that completes while the previous one is unread raises an overrun error. The error is cleared by dropping the continuous enable.

Top module: `sync_rx_master`

## Requirements
- R1: After reset `rx_data`, `rx_flag`, `ovr_err`, `irq`, `single_en` and `sck` are all 0. The value of `rx_bit9` after reset is not specified.
- R2: `sck` stays low unless `port_en`, `master_sel` and at least one of `single_en` / `cont_en` are all high. The cycle after this condition is lost, `sck` is low.
- R3: While clocking, each high phase and each low phase of `sck` lasts 2*(`baud_div`+1) system clocks, so one shift-clock period is 4*(`baud_div`+1) system clocks. Clocking starts with a low phase.
- R4: `sdi` is sampled at each high-to-low transition of `sck`. The first sample of a word lands in `rx_data[0]` and the eighth in `rx_data[7]`.
- R5: With only the one-shot enable active, exactly one word is received. `single_en` then returns to 0 and `sck` stays low.
- R6: With `cont_en` high, words are received back to back, each starting right after the previous one, until `cont_en` is cleared.
- R7: When both enables are active, the continuous enable takes precedence: `single_en` stays 1 across completed words and clocking continues.
- R8: With `nine_bit_en` high, a word is nine samples long. The ninth sample goes to `rx_bit9` and `rx_data` holds the first eight.
- R9: `rx_flag` rises only when a word completes. `irq` equals `rx_flag` gated by `irq_en`.
- R10: A pulse on `rd_strobe` clears `rx_flag` in the following cycle.
- R11: If a word completes while `rx_flag` is still set, `ovr_err` becomes 1 and the new word is discarded, leaving `rx_data` unchanged.
- R12: `ovr_err` clears on the cycle after a high-to-low change of `cont_en`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| port_en | input | 1 | Serial port enable |
| master_sel | input | 1 | Selects synchronous master operation |
| nine_bit_en | input | 1 | Nine-bit word mode |
| single_set | input | 1 | One-cycle pulse that sets the one-shot receive enable |
| cont_en | input | 1 | Continuous receive enable (level) |
| irq_en | input | 1 | Receive interrupt enable |
| baud_div | input | DIV_W | Shift-clock divider value |
| rd_strobe | input | 1 | One-cycle read of the data register; clears the flag |
| sdi | input | 1 | Serial data input |
| sck | output | 1 | Generated shift clock, idles low |
| single_en | output | 1 | Readback of the one-shot receive enable |
| rx_data | output | 8 | Received data register |
| rx_bit9 | output | 1 | Ninth received bit |
| rx_flag | output | 1 | Receive-complete flag |
| ovr_err | output | 1 | Overrun error |
| irq | output | 1 | Receive interrupt request |

## Verification
The assertions assume that `baud_div` and `nine_bit_en` do not change while `sck` is toggling. They also assume that `rd_strobe` and `single_set` are single-cycle pulses. The bench changes the divider and word-length setting only while the clock is idle, and it drives every strobe for exactly one cycle. It drives `sdi` one system-clock phase after each rising `sck`, so the line is stable over the whole high phase and at the sampling edge.

// File: rtl/srx_pkg.sv
package srx_pkg;
  localparam int DATA_W = 8;
  localparam int WORD_W = DATA_W + 1;
  localparam int IDX_W  = $clog2(WORD_W);

  // Number of system clocks in one half shift-clock period
  function automatic int unsigned half_len(input int unsigned div);
    return 2 * (div + 1);
  endfunction

  // Index of the final sample in a word
  function automatic logic [IDX_W-1:0] last_index(input logic nine);
    return nine ? IDX_W'(DATA_W) : IDX_W'(DATA_W - 1);
  endfunction
endpackage

// File: rtl/srx_clkgen.sv
module srx_clkgen #(
  parameter int DIV_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run,
  input  logic [DIV_W-1:0] div,
  output logic             sck,
  output logic             rise_tick,
  output logic             fall_tick
);
  localparam int CNT_W = DIV_W + 1;

  logic [CNT_W-1:0] hcnt;
  logic             term;

  // Terminal count of a half period: 2*(div+1)-1
  function automatic logic [CNT_W-1:0] half_term(input logic [DIV_W-1:0] d);
    return {d, 1'b1};
  endfunction

  assign term      = run && (hcnt == half_term(div));
  assign rise_tick = term && !sck;
  assign fall_tick = term && sck;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hcnt <= '0;
      sck  <= 1'b0;
    end else if (!run) begin
      hcnt <= '0;
      sck  <= 1'b0;
    end else if (term) begin
      hcnt <= '0;
      sck  <= ~sck;
    end else begin
      hcnt <= hcnt + 1'b1;
    end
  end
endmodule

// File: rtl/srx_shifter.sv
module srx_shifter
  import srx_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              run,
  input  logic              fall_tick,
  input  logic              sdi,
  input  logic              nine,
  output logic              word_done,
  output logic [WORD_W-1:0] word
);
  logic [IDX_W-1:0]  bcnt;
  logic [WORD_W-1:0] sh;
  logic              at_last;

  assign at_last   = (bcnt == last_index(nine));
  assign word_done = fall_tick && at_last;

  // Word as it stands including the sample being taken this cycle
  always_comb begin
    word = sh;
    if (fall_tick) word[bcnt] = sdi;
    if (!nine) word[WORD_W-1] = 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      bcnt <= '0;
      sh   <= '0;
    end else if (!run) begin
      bcnt <= '0;
    end else if (fall_tick) begin
      sh[bcnt] <= sdi;
      bcnt     <= at_last ? '0 : bcnt + 1'b1;
    end
  end
endmodule

// File: rtl/srx_flags.sv
module srx_flags
  import srx_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              word_done,
  input  logic [WORD_W-1:0] word,
  input  logic              nine,
  input  logic              rd_strobe,
  input  logic              single_set,
  input  logic              cont_en,
  input  logic              irq_en,
  output logic              single_en,
  output logic [DATA_W-1:0] rx_data,
  output logic              rx_bit9,
  output logic              rx_flag,
  output logic              ovr_err,
  output logic              irq
);
  logic cont_q;
  logic cont_fall;
  logic flag_after_rd;
  logic store;
  logic overrun;

  assign cont_fall     = cont_q && !cont_en;
  assign flag_after_rd = rx_flag && !rd_strobe;
  assign store         = word_done && !flag_after_rd;
  assign overrun       = word_done && flag_after_rd;
  assign irq           = rx_flag && irq_en;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cont_q    <= 1'b0;
      single_en <= 1'b0;
      rx_data   <= '0;
      rx_flag   <= 1'b0;
      ovr_err   <= 1'b0;
    end else begin
      cont_q <= cont_en;
      if (single_set)                   single_en <= 1'b1;
      else if (word_done && !cont_en)   single_en <= 1'b0;
      if (store) begin
        rx_data <= word[DATA_W-1:0];
        rx_flag <= 1'b1;
      end else if (rd_strobe) begin
        rx_flag <= 1'b0;
      end
      if (overrun)        ovr_err <= 1'b1;
      else if (cont_fall) ovr_err <= 1'b0;
    end
  end

  // Ninth bit has no defined reset value
  always_ff @(posedge clk) begin
    if (store && nine) rx_bit9 <= word[WORD_W-1];
  end
endmodule

// File: rtl/sync_rx_master.sv
module sync_rx_master
  import srx_pkg::*;
#(
  parameter int DIV_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              port_en,
  input  logic              master_sel,
  input  logic              nine_bit_en,
  input  logic              single_set,
  input  logic              cont_en,
  input  logic              irq_en,
  input  logic [DIV_W-1:0]  baud_div,
  input  logic              rd_strobe,
  input  logic              sdi,
  output logic              sck,
  output logic              single_en,
  output logic [DATA_W-1:0] rx_data,
  output logic              rx_bit9,
  output logic              rx_flag,
  output logic              ovr_err,
  output logic              irq
);
  logic              run;
  logic              rise_tick;
  logic              fall_tick;
  logic              word_done;
  logic [WORD_W-1:0] word;

  assign run = port_en && master_sel && (single_en || cont_en);

  srx_clkgen #(.DIV_W(DIV_W)) u_clk (
    .clk(clk), .rst_n(rst_n), .run(run), .div(baud_div),
    .sck(sck), .rise_tick(rise_tick), .fall_tick(fall_tick)
  );

  srx_shifter u_shift (
    .clk(clk), .rst_n(rst_n), .run(run), .fall_tick(fall_tick),
    .sdi(sdi), .nine(nine_bit_en), .word_done(word_done), .word(word)
  );

  srx_flags u_flags (
    .clk(clk), .rst_n(rst_n), .word_done(word_done), .word(word),
    .nine(nine_bit_en), .rd_strobe(rd_strobe), .single_set(single_set),
    .cont_en(cont_en), .irq_en(irq_en), .single_en(single_en),
    .rx_data(rx_data), .rx_bit9(rx_bit9), .rx_flag(rx_flag),
    .ovr_err(ovr_err), .irq(irq)
  );
endmodule

// File: rtl/srx_chk.sv
module srx_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       port_en,
  input logic       master_sel,
  input logic       single_en,
  input logic       cont_en,
  input logic       sck,
  input logic       fall_tick,
  input logic       word_done,
  input logic       rd_strobe,
  input logic       rx_flag,
  input logic       ovr_err,
  input logic [7:0] rx_data,
  input logic       irq_en,
  input logic       irq
);
  a_r2_idle_low: assert property (@(posedge clk) disable iff (!rst_n)
    !(port_en && master_sel && (single_en || cont_en)) |=> !sck);

  a_r4_sample_while_high: assert property (@(posedge clk) disable iff (!rst_n)
    fall_tick |-> sck);

  a_r5_single_self_clear: assert property (@(posedge clk) disable iff (!rst_n)
    word_done && !cont_en |=> !single_en);

  a_r7_cont_precedence: assert property (@(posedge clk) disable iff (!rst_n)
    word_done && cont_en && single_en |=> single_en);

  a_r9_flag_source: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rx_flag) |-> $past(word_done));

  a_r9_irq_gated: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> (irq_en && rx_flag));

  a_r10_read_clears: assert property (@(posedge clk) disable iff (!rst_n)
    rd_strobe && !word_done |=> !rx_flag);

  a_r11_overrun: assert property (@(posedge clk) disable iff (!rst_n)
    word_done && rx_flag && !rd_strobe |=> ovr_err && $stable(rx_data));
endmodule

bind sync_rx_master srx_chk u_chk (
  .clk(clk), .rst_n(rst_n), .port_en(port_en), .master_sel(master_sel),
  .single_en(single_en), .cont_en(cont_en), .sck(sck), .fall_tick(fall_tick),
  .word_done(word_done), .rd_strobe(rd_strobe), .rx_flag(rx_flag),
  .ovr_err(ovr_err), .rx_data(rx_data), .irq_en(irq_en), .irq(irq)
);

// File: tb/sim_sync_rx_master.sv
`timescale 1ns/1ps
module sim_sync_rx_master;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       port_en = 1'b0, master_sel = 1'b0, nine_bit_en = 1'b0;
  logic       single_set = 1'b0, cont_en = 1'b0, irq_en = 1'b0;
  logic [7:0] baud_div = 8'd0;
  logic       rd_strobe = 1'b0, sdi = 1'b0;
  logic       sck, single_en, rx_bit9, rx_flag, ovr_err, irq;
  logic [7:0] rx_data;

  int n_chk = 0, n_fail = 0;
  logic [63:0] stream = '0;
  int ptr = 0, hi_run = 0, lo_run = 0, last_hi = 0, last_lo = 0, rises = 0;
  logic sck_prev = 1'b0;
  logic finished = 1'b0;

  always #2.5 clk = ~clk;

  sync_rx_master #(.DIV_W(8)) u0 (
    .clk(clk), .rst_n(rst_n), .port_en(port_en), .master_sel(master_sel),
    .nine_bit_en(nine_bit_en), .single_set(single_set), .cont_en(cont_en),
    .irq_en(irq_en), .baud_div(baud_div), .rd_strobe(rd_strobe), .sdi(sdi),
    .sck(sck), .single_en(single_en), .rx_data(rx_data), .rx_bit9(rx_bit9),
    .rx_flag(rx_flag), .ovr_err(ovr_err), .irq(irq)
  );

  // Serial source: presents the next stream bit after each rising sck
  initial begin
    forever begin
      @(negedge clk);
      if (sck && !sck_prev) begin
        sdi = stream[ptr];
        ptr++;
        rises++;
        last_lo = lo_run;
        lo_run = 0;
      end
      if (!sck && sck_prev) begin
        last_hi = hi_run;
        hi_run = 0;
      end
      if (sck) hi_run++; else lo_run++;
      sck_prev = sck;
    end
  end

  task automatic check(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic pulse_single();
    @(negedge clk); single_set = 1'b1;
    @(negedge clk); single_set = 1'b0;
  endtask

  task automatic pulse_read();
    @(negedge clk); rd_strobe = 1'b1;
    @(negedge clk); rd_strobe = 1'b0;
  endtask

  task automatic wait_flag(input string req);
    int t = 0;
    while (!rx_flag && t < 20000) begin @(negedge clk); t++; end
    check(req, int'(rx_flag), 1);
  endtask

  task automatic load(input logic [63:0] s);
    stream = s;
    ptr = 0;
  endtask

  // {div[7:0], nine, data[8:0]}
  localparam logic [17:0] VEC [6] = '{
    {8'd0, 1'b0, 9'h0A5},
    {8'd1, 1'b1, 9'h13C},
    {8'd3, 1'b0, 9'h0FF},
    {8'd0, 1'b1, 9'h001},
    {8'd2, 1'b0, 9'h080},
    {8'd5, 1'b1, 9'h155}
  };

  initial begin
    int cyc = 0;
    while (!finished && cyc < 150000) begin @(posedge clk); cyc++; end
    if (!finished) begin
      n_fail++; n_chk++;
      $display("FAIL watchdog actual=%0d expected=0", cyc);
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    check("R1 rx_data", int'(rx_data), 0);
    check("R1 rx_flag", int'(rx_flag), 0);
    check("R1 ovr_err", int'(ovr_err), 0);
    check("R1 irq", int'(irq), 0);
    check("R1 sck", int'(sck), 0);
    rst_n = 1'b1;
    @(negedge clk);
    check("R1 single_en", int'(single_en), 0);

    // R2: enable set but master mode off -> no clock
    port_en = 1'b1; cont_en = 1'b1;
    repeat (50) @(negedge clk);
    check("R2 no clocks without master", rises, 0);
    check("R2 no flag", int'(rx_flag), 0);
    cont_en = 1'b0;
    master_sel = 1'b1;
    repeat (20) @(negedge clk);
    check("R2 idle without enables", rises, 0);

    // Table of single-word receptions
    foreach (VEC[i]) begin
      logic [7:0] d;
      logic n;
      logic [8:0] w;
      d = VEC[i][17:10]; n = VEC[i][9]; w = VEC[i][8:0];
      baud_div = d; nine_bit_en = n; irq_en = i[0];
      load({55'd0, w});
      pulse_single();
      wait_flag("R9 flag after word");
      check("R4 data lsb first", int'(rx_data), int'(w[7:0]));
      if (n) check("R8 ninth bit", int'(rx_bit9), int'(w[8]));
      check("R3 high phase", last_hi, 2 * (int'(d) + 1));
      check("R3 low phase", last_lo, 2 * (int'(d) + 1));
      check("R9 irq gated", int'(irq), i[0] ? 1 : 0);
      repeat (3) @(negedge clk);
      check("R5 single cleared", int'(single_en), 0);
      check("R5 one word of clocks", rises, n ? 9 : 8);
      repeat (40) @(negedge clk);
      check("R5 clock stopped", int'(sck), 0);
      pulse_read();
      check("R10 read clears flag", int'(rx_flag), 0);
      check("R9 irq drops", int'(irq), 0);
      rises = 0;
    end

    // R6: continuous back-to-back words
    baud_div = 8'd1; nine_bit_en = 1'b0; irq_en = 1'b0;
    load({48'd0, 8'hC3, 8'h5A});
    @(negedge clk); cont_en = 1'b1;
    wait_flag("R6 first word");
    check("R6 word0", int'(rx_data), 8'h5A);
    pulse_read();
    wait_flag("R6 second word");
    check("R6 word1", int'(rx_data), 8'hC3);
    check("R6 no overrun", int'(ovr_err), 0);
    cont_en = 1'b0;
    pulse_read();
    repeat (20) @(negedge clk);
    check("R6 stop on clear", int'(sck), 0);
    rises = 0;

    // R7: both enables set -> continuous wins
    load({48'd0, 8'h66, 8'h99});
    @(negedge clk); cont_en = 1'b1;
    pulse_single();
    wait_flag("R7 first word");
    check("R7 word0", int'(rx_data), 8'h99);
    pulse_read();
    repeat (4) @(negedge clk);
    check("R7 single stays", int'(single_en), 1);
    wait_flag("R7 second word");
    check("R7 word1", int'(rx_data), 8'h66);
    check("R7 clocking continued", rises >= 16 ? 1 : 0, 1);
    pulse_read();
    cont_en = 1'b0;
    begin
      int t = 0;
      while (single_en && t < 5000) begin @(negedge clk); t++; end
    end
    check("R5 single drops after final word", int'(single_en), 0);
    pulse_read();

    // R11: overrun when the previous word is unread
    load({48'd0, 8'h3E, 8'h81});
    pulse_single();
    wait_flag("R11 first word");
    repeat (3) @(negedge clk);
    ptr = 8;
    pulse_single();
    begin
      int t = 0;
      while (!ovr_err && t < 5000) begin @(negedge clk); t++; end
    end
    check("R11 overrun set", int'(ovr_err), 1);
    check("R11 data kept", int'(rx_data), 8'h81);

    // R12: dropping the continuous enable clears the error
    port_en = 1'b0;
    @(negedge clk); cont_en = 1'b1;
    repeat (3) @(negedge clk);
    check("R12 error held while enabled", int'(ovr_err), 1);
    cont_en = 1'b0;
    repeat (2) @(negedge clk);
    check("R12 error cleared", int'(ovr_err), 0);

    finished = 1'b1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule